// File: doc/BRIEF.md
# Field Line-Doubling Scan Converter

This block turns an interlaced camera field stream into progressive output lines by presenting every captured camera line twice. Camera pixels arrive on a one-in-two clock enable, qualified by a line-valid input; a field sync marks each new field. Each line is written into one of two line buffers. When the line ends, that buffer is replayed twice at the full clock rate while the next camera line goes into the other buffer. A field of 240 lines therefore fills 480 output lines in the same field period.

The horizontal output timing is made inside the block: an active region, a front porch, a sync pulse (active low) and a back porch, with a data-enable that is high only while stored pixels are shown. The vertical sync is the camera's field sync, passed straight through. When no new camera line is ready at the end of a line pair, the horizontal timing keeps running and the pair is blanked. A rising field sync stops the output timing. Output restarts with the first complete line of the new field.

Top module: `line_doubler`

## Requirements
- R1: After reset, and until the first camera line has completed, `vga_de` is 0, `vga_hsync_n` is 1 and `vga_rgb` is 0.
- R2: `vga_vsync` equals `cam_vsync` in the same cycle, with no register in the path.
- R3: A pixel is stored only on a clock where `pix_en` and `cam_href` are both 1. The first ACT_PIX such pixels of a line go to buffer addresses 0, 1, 2, ... in order, and any further pixels of that line are discarded.
- R4: A line completes at the first `pix_en` sample where `cam_href` is 0 after a sample where it was 1. Successive lines are written to alternating buffers, so the next line never overwrites the line being replayed.
- R5: Every completed line appears as exactly two consecutive output lines. In each of them `vga_de` is 1 for ACT_PIX consecutive clocks, and `vga_rgb` carries the stored pixels in address order.
- R6: An output line lasts ACT_PIX+H_FP+H_SYNC+H_BP clocks. `vga_hsync_n` is 0 for H_SYNC clocks, and its falling edge comes H_FP clocks after the falling edge of `vga_de`.
- R7: `vga_rgb` is 0 in every cycle where `vga_de` is 0.
- R8: Two clocks after the first clock edge that samples `cam_vsync` high following a low sample, `vga_hsync_n` is 1 and `vga_de` is 0. They stay so until the first line of the new field completes.
- R9: A line that completes exactly at the end of a line pair starts the next pair with no gap, so `vga_de` rises exactly one output line period apart. If no line has completed by the end of a pair, a blank pair follows: `vga_hsync_n` keeps pulsing and `vga_de` stays 0. A line that completes later is shown from the next pair boundary.
- R10: `vga_de` is never 1 while `vga_hsync_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output pixel clock (twice the camera pixel rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Camera pixel strobe, high on every second clock |
| cam_href | input | 1 | Camera line-valid, sampled when `pix_en` is 1 |
| cam_vsync | input | 1 | Camera field sync, active high |
| cam_pix | input | PIX_W | Camera RGB pixel |
| vga_rgb | output | PIX_W | Output pixel, 0 outside active video |
| vga_hsync_n | output | 1 | Generated horizontal sync, active low |
| vga_vsync | output | 1 | Field sync passed through |
| vga_de | output | 1 | Output data-enable |

## Verification
The hardest case to reach is a line that completes out of step with the pair boundary. The pending-start path and the blank pair only come into play when a camera line runs longer than one input line period. The bench ends one field with a line four pixels too long. This line completes eight clocks after a pair boundary, and the bench expects the next enable rise three output line periods after the previous one, with the first ACT_PIX pixels intact. The bench also drives inverted junk onto the pixel bus in every cycle without the enable, so any sample taken off the strobe corrupts the pixel comparison.

// File: rtl/ld_pkg.sv
`timescale 1ns/1ps
package ld_pkg;
    // Identifies one of the two line banks.
    typedef enum logic {
        BANK_0 = 1'b0,
        BANK_1 = 1'b1
    } bank_e;

    // Output horizontal timer running or parked.
    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_mode_e;
endpackage

// File: rtl/ld_capture.sv
`timescale 1ns/1ps
module ld_capture
    import ld_pkg::*;
#(
    parameter  int ACT_PIX = 640,
    parameter  int PIX_W   = 16,
    localparam int AW      = $clog2(ACT_PIX),
    localparam int CW      = $clog2(ACT_PIX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic             href,
    input  logic             vsync,
    input  logic [PIX_W-1:0] pix,
    output logic             wr_en,
    output bank_e            wr_sel,
    output logic [AW-1:0]    wr_addr,
    output logic [PIX_W-1:0] wr_data,
    output logic             line_done,
    output bank_e            done_sel,
    output logic             field_start
);
    localparam logic [CW-1:0] ADDR_FULL = CW'(ACT_PIX);

    typedef struct packed {
        logic          href;
        logic          vs;
        bank_e         wsel;
        logic [CW-1:0] waddr;
        logic          done;
        bank_e         dsel;
    } cap_t;

    cap_t cap_q, cap_d;

    always_comb begin
        cap_d       = cap_q;
        cap_d.done  = 1'b0;
        cap_d.vs    = vsync;
        field_start = vsync & ~cap_q.vs;
        wr_en       = 1'b0;
        if (field_start) begin
            // A line cut by the field sync is dropped.
            cap_d.waddr = '0;
            cap_d.href  = 1'b0;
        end else if (pix_en) begin
            cap_d.href = href;
            if (href && (cap_q.waddr != ADDR_FULL)) begin
                wr_en       = 1'b1;
                cap_d.waddr = cap_q.waddr + CW'(1);
            end
            if (!href && cap_q.href) begin
                cap_d.done  = 1'b1;
                cap_d.dsel  = cap_q.wsel;
                cap_d.wsel  = bank_e'(~cap_q.wsel);
                cap_d.waddr = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign wr_sel    = cap_q.wsel;
    assign wr_addr   = cap_q.waddr[AW-1:0];
    assign wr_data   = pix;
    assign line_done = cap_q.done;
    assign done_sel  = cap_q.dsel;
endmodule

// File: rtl/ld_line_store.sv
`timescale 1ns/1ps
module ld_line_store
    import ld_pkg::*;
#(
    parameter  int DEPTH = 640,
    parameter  int PIX_W = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  bank_e            wr_sel,
    input  logic [AW-1:0]    wr_addr,
    input  logic [PIX_W-1:0] wr_data,
    input  bank_e            rd_sel,
    input  logic [AW-1:0]    rd_addr,
    output logic [PIX_W-1:0] rd_data
);
    logic [1:0][PIX_W-1:0] bank_rd;
    bank_e                 rsel_q;

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [PIX_W-1:0] mem [DEPTH];
        logic [PIX_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_en && (logic'(wr_sel) == 1'(g))) begin
                mem[wr_addr] <= wr_data;
            end
            rd_q <= mem[rd_addr];
        end

        assign bank_rd[g] = rd_q;
    end

    always_ff @(posedge clk) begin
        rsel_q <= rd_sel;
    end

    assign rd_data = bank_rd[rsel_q];
endmodule

// File: rtl/ld_scan_timer.sv
`timescale 1ns/1ps
module ld_scan_timer
    import ld_pkg::*;
#(
    parameter  int ACT_PIX = 640,
    parameter  int H_FP    = 16,
    parameter  int H_SYNC  = 96,
    parameter  int H_BP    = 48,
    localparam int TOTAL   = ACT_PIX + H_FP + H_SYNC + H_BP,
    localparam int HW      = $clog2(TOTAL),
    localparam int AW      = $clog2(ACT_PIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_done,
    input  bank_e         done_sel,
    input  logic          field_start,
    output bank_e         rd_sel,
    output logic [AW-1:0] rd_addr,
    output logic          pix_act,
    output logic          sync_act
);
    localparam logic [HW-1:0] H_LAST     = HW'(TOTAL - 1);
    localparam logic [HW-1:0] H_ACT_END  = HW'(ACT_PIX);
    localparam logic [HW-1:0] H_SYNC_BEG = HW'(ACT_PIX + H_FP);
    localparam logic [HW-1:0] H_SYNC_END = HW'(ACT_PIX + H_FP + H_SYNC);

    typedef struct packed {
        scan_mode_e    mode;
        logic [HW-1:0] hcnt;
        logic          rep;
        bank_e         rsel;
        logic          show;
        logic          pend;
        bank_e         psel;
    } scan_t;

    scan_t sc_q, sc_d;
    logic  line_end;
    logic  pair_end;
    logic  running;

    always_comb begin
        sc_d     = sc_q;
        running  = (sc_q.mode == SCAN_RUN);
        line_end = (sc_q.hcnt == H_LAST);
        pair_end = line_end && sc_q.rep;
        if (field_start) begin
            sc_d.mode = SCAN_IDLE;
            sc_d.hcnt = '0;
            sc_d.rep  = 1'b0;
            sc_d.show = 1'b0;
            sc_d.pend = 1'b0;
        end else if (!running) begin
            if (line_done) begin
                sc_d.mode = SCAN_RUN;
                sc_d.hcnt = '0;
                sc_d.rep  = 1'b0;
                sc_d.rsel = done_sel;
                sc_d.show = 1'b1;
            end
        end else if (pair_end) begin
            sc_d.hcnt = '0;
            sc_d.rep  = 1'b0;
            sc_d.pend = 1'b0;
            sc_d.show = line_done || sc_q.pend;
            if (line_done) begin
                sc_d.rsel = done_sel;
            end else if (sc_q.pend) begin
                sc_d.rsel = sc_q.psel;
            end
        end else begin
            if (line_done) begin
                sc_d.pend = 1'b1;
                sc_d.psel = done_sel;
            end
            if (line_end) begin
                sc_d.hcnt = '0;
                sc_d.rep  = 1'b1;
            end else begin
                sc_d.hcnt = sc_q.hcnt + HW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_q <= '0;
        end else begin
            sc_q <= sc_d;
        end
    end

    assign pix_act  = running && sc_q.show && (sc_q.hcnt < H_ACT_END);
    assign sync_act = running && (sc_q.hcnt >= H_SYNC_BEG) && (sc_q.hcnt < H_SYNC_END);
    assign rd_sel   = sc_q.rsel;
    assign rd_addr  = pix_act ? sc_q.hcnt[AW-1:0] : '0;
endmodule

// File: rtl/line_doubler.sv
`timescale 1ns/1ps
module line_doubler
    import ld_pkg::*;
#(
    parameter int ACT_PIX = 640,
    parameter int H_FP    = 16,
    parameter int H_SYNC  = 96,
    parameter int H_BP    = 48,
    parameter int PIX_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic             cam_href,
    input  logic             cam_vsync,
    input  logic [PIX_W-1:0] cam_pix,
    output logic [PIX_W-1:0] vga_rgb,
    output logic             vga_hsync_n,
    output logic             vga_vsync,
    output logic             vga_de
);
    localparam int AW = $clog2(ACT_PIX);

    logic             wr_en;
    bank_e            wr_sel;
    logic [AW-1:0]    wr_addr;
    logic [PIX_W-1:0] wr_data;
    logic             line_done;
    bank_e            done_sel;
    logic             field_start;
    bank_e            rd_sel;
    logic [AW-1:0]    rd_addr;
    logic [PIX_W-1:0] rd_data;
    logic             pix_act;
    logic             sync_act;

    ld_capture #(
        .ACT_PIX (ACT_PIX),
        .PIX_W   (PIX_W)
    ) cap_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_en      (pix_en),
        .href        (cam_href),
        .vsync       (cam_vsync),
        .pix         (cam_pix),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .line_done   (line_done),
        .done_sel    (done_sel),
        .field_start (field_start)
    );

    ld_line_store #(
        .DEPTH (ACT_PIX),
        .PIX_W (PIX_W)
    ) store_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    ld_scan_timer #(
        .ACT_PIX (ACT_PIX),
        .H_FP    (H_FP),
        .H_SYNC  (H_SYNC),
        .H_BP    (H_BP)
    ) scan_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_done   (line_done),
        .done_sel    (done_sel),
        .field_start (field_start),
        .rd_sel      (rd_sel),
        .rd_addr     (rd_addr),
        .pix_act     (pix_act),
        .sync_act    (sync_act)
    );

    // Output stage: aligns enable and sync with the one-cycle buffer read.
    typedef struct packed {
        logic de;
        logic hs_n;
    } out_t;

    out_t out_q, out_d;

    always_comb begin
        out_d      = out_q;
        out_d.de   = pix_act;
        out_d.hs_n = ~sync_act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '{de: 1'b0, hs_n: 1'b1};
        end else begin
            out_q <= out_d;
        end
    end

    assign vga_de      = out_q.de;
    assign vga_hsync_n = out_q.hs_n;
    assign vga_rgb     = out_q.de ? rd_data : '0;
    assign vga_vsync   = cam_vsync;
endmodule

// File: rtl/ld_checker.sv
`timescale 1ns/1ps
module ld_checker #(
    parameter int ACT_PIX = 640,
    parameter int H_SYNC  = 96
) (
    input logic clk,
    input logic rst_n,
    input logic cam_vsync,
    input logic vga_de,
    input logic vga_hsync_n
);
    logic [15:0] hs_len;
    logic [15:0] de_len;
    logic [1:0]  quiet;
    logic        vs_q;
    logic        hs_p;
    logic        de_p;
    logic        hs_cut;
    logic        de_cut;
    logic        vs_edge;

    assign vs_edge = cam_vsync && !vs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_len <= '0;
            de_len <= '0;
            quiet  <= '0;
            vs_q   <= 1'b0;
            hs_p   <= 1'b1;
            de_p   <= 1'b0;
            hs_cut <= 1'b0;
            de_cut <= 1'b0;
        end else begin
            vs_q   <= cam_vsync;
            hs_p   <= vga_hsync_n;
            de_p   <= vga_de;
            hs_len <= vga_hsync_n ? 16'd0 : hs_len + 16'd1;
            de_len <= vga_de ? de_len + 16'd1 : 16'd0;
            if (vs_edge) begin
                quiet <= 2'd3;
            end else if (quiet != 2'd0) begin
                quiet <= quiet - 2'd1;
            end
            if (vs_edge || (quiet != 2'd0)) begin
                hs_cut <= 1'b1;
                de_cut <= 1'b1;
            end else begin
                if (hs_p && !vga_hsync_n) hs_cut <= 1'b0;
                if (!de_p && vga_de)      de_cut <= 1'b0;
            end
        end
    end

    AST_DE_CLEAR_OF_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !vga_hsync_n |-> !vga_de); // R10

    AST_DE_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(vga_de) && !de_cut) |-> (de_len == 16'(ACT_PIX))); // R5

    AST_SYNC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vga_hsync_n) && !hs_cut) |-> (hs_len == 16'(H_SYNC))); // R6

    AST_DE_FALL_IN_PORCH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vga_de) |-> vga_hsync_n); // R6

    AST_FIELD_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cam_vsync) |=> ##1 (vga_hsync_n && !vga_de)); // R8
endmodule

bind line_doubler ld_checker #(
    .ACT_PIX (ACT_PIX),
    .H_SYNC  (H_SYNC)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cam_vsync   (cam_vsync),
    .vga_de      (vga_de),
    .vga_hsync_n (vga_hsync_n)
);

// File: tb/line_doubler_tb_top.sv
`timescale 1ns/1ps
module line_doubler_tb_top;
    localparam int ACT = 16;
    localparam int FP  = 2;
    localparam int SY  = 4;
    localparam int BP  = 2;
    localparam int TOT = ACT + FP + SY + BP;
    localparam int PW  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_en = 1'b0;
    logic          cam_href = 1'b0;
    logic          cam_vsync = 1'b0;
    logic [PW-1:0] cam_pix = '0;
    logic [PW-1:0] vga_rgb;
    logic          vga_hsync_n;
    logic          vga_vsync;
    logic          vga_de;

    always #4 clk = ~clk;

    line_doubler #(
        .ACT_PIX (ACT),
        .H_FP    (FP),
        .H_SYNC  (SY),
        .H_BP    (BP),
        .PIX_W   (PW)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_en      (pix_en),
        .cam_href    (cam_href),
        .cam_vsync   (cam_vsync),
        .cam_pix     (cam_pix),
        .vga_rgb     (vga_rgb),
        .vga_hsync_n (vga_hsync_n),
        .vga_vsync   (vga_vsync),
        .vga_de      (vga_de)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 1'b0;

    int            sent_id [64];
    bit            sent_long [64];
    int            nsent = 0;
    int            out_runs = 0;
    int            pos = 0;
    logic [PW-1:0] cap [ACT];
    bit            mon_on = 1'b0;
    bit            await_first = 1'b0;
    bit            de_p = 1'b0, hs_p = 1'b1, vs_p = 1'b0;
    int            de_rise_t = 0, hs_fall_t = 0, de_fall_t = 0;
    bit            de_rise_v = 1'b0, hs_fall_v = 1'b0, de_fell = 1'b0;
    int            hs_since_de = 0;
    int            vs_hold = 0;

    function automatic logic [PW-1:0] pv(int id, int x);
        return {id[9:0], x[5:0]};
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (mon_on) begin
            if (cam_vsync && !vs_p) vs_hold = 4;
            if (vs_hold > 0) begin
                vs_hold--;
                hs_fall_v = 1'b0;
                de_rise_v = 1'b0;
                de_fell   = 1'b0;
            end
            chk(vga_vsync === cam_vsync, "R2 vsync pass-through", int'(vga_vsync), int'(cam_vsync));
            if (!vga_de) chk(vga_rgb == '0, "R7 rgb zero in blanking", int'(vga_rgb), 0);
            if (await_first) begin
                chk(vga_hsync_n && !vga_de, "R8 quiet until first line",
                    int'({vga_hsync_n, vga_de}), 2);
            end
            if (vga_de && !de_p) begin
                if (de_rise_v) begin
                    int exp_gap;
                    exp_gap = TOT;
                    if ((out_runs % 2 == 0) && (out_runs / 2 < nsent) && sent_long[out_runs / 2])
                        exp_gap = 3 * TOT;
                    chk(cyc - de_rise_t == exp_gap, "R9 line pair spacing", cyc - de_rise_t, exp_gap);
                end
                de_rise_t   = cyc;
                de_rise_v   = 1'b1;
                hs_since_de = 0;
                pos         = 0;
            end
            if (vga_de) begin
                if (pos < ACT) cap[pos] = vga_rgb;
                pos++;
            end
            if (!vga_de && de_p) begin
                int idx;
                int bad_x;
                idx   = out_runs / 2;
                bad_x = -1;
                chk(pos == ACT, "R5 enable run length", pos, ACT);
                if (idx < nsent) begin
                    for (int x = 0; x < ACT; x++) begin
                        if (bad_x < 0 && cap[x] !== pv(sent_id[idx], x)) bad_x = x;
                    end
                    if (bad_x < 0) chk(1'b1, "R5 R3 R4 pixel content", 0, 0);
                    else chk(1'b0, "R5 R3 R4 pixel content", int'(cap[bad_x]),
                             int'(pv(sent_id[idx], bad_x)));
                end else begin
                    chk(1'b0, "R5 extra output line", idx, nsent - 1);
                end
                out_runs++;
                de_fall_t = cyc;
                de_fell   = 1'b1;
            end
            if (!vga_hsync_n && hs_p) begin
                if (hs_fall_v) chk(cyc - hs_fall_t == TOT, "R6 line period", cyc - hs_fall_t, TOT);
                if (de_fell) chk(cyc - de_fall_t == FP, "R6 front porch", cyc - de_fall_t, FP);
                de_fell   = 1'b0;
                hs_fall_t = cyc;
                hs_fall_v = 1'b1;
                hs_since_de++;
            end
            if (vga_hsync_n && !hs_p && hs_fall_v) begin
                chk(cyc - hs_fall_t == SY, "R6 sync width", cyc - hs_fall_t, SY);
            end
        end
        de_p = vga_de;
        hs_p = vga_hsync_n;
        vs_p = cam_vsync;
    end

    // One camera pixel slot: two clocks, strobe on the first only.
    task automatic sample(bit h, logic [PW-1:0] p, bit vs);
        @(posedge clk);
        #1;
        pix_en    = 1'b1;
        cam_href  = h;
        cam_pix   = p;
        cam_vsync = vs;
        @(posedge clk);
        #1;
        pix_en  = 1'b0;
        cam_pix = ~p;
    endtask

    task automatic send_field(int fid, int nlines, bit long_last);
        for (int i = 0; i < 5; i++) begin
            sample(1'b0, 16'h5A5A, 1'b1);
            if (i == 1) await_first = 1'b1;
        end
        for (int i = 0; i < 10; i++) sample(1'b0, 16'hC3C3, 1'b0);
        for (int l = 0; l < nlines; l++) begin
            int id;
            int len;
            bit lng;
            id  = fid * 32 + l;
            lng = long_last && (l == nlines - 1);
            len = lng ? ACT + 4 : ACT;
            sent_id[nsent]   = id;
            sent_long[nsent] = lng;
            nsent++;
            for (int x = 0; x < len; x++) sample(1'b1, pv(id, x), 1'b0);
            if (l == 0) await_first = 1'b0;
            for (int x = 0; x < 8; x++) sample(1'b0, 16'h0F0F, 1'b0);
        end
        for (int i = 0; i < 60; i++) sample(1'b0, 16'h3C3C, 1'b0);
        #2;
        chk(hs_since_de >= 3, "R9 sync continues on blank pairs", hs_since_de, 3);
        chk(vga_de == 1'b0, "R9 enable low after last pair", int'(vga_de), 0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        chk(vga_de == 1'b0, "R1 reset enable", int'(vga_de), 0);
        chk(vga_hsync_n == 1'b1, "R1 reset hsync", int'(vga_hsync_n), 1);
        chk(vga_rgb == '0, "R1 reset rgb", int'(vga_rgb), 0);
        mon_on = 1'b1;
        // Strobed pixels without line-valid must start nothing.
        for (int i = 0; i < 30; i++) sample(1'b0, 16'(i * 77), 1'b0);
        #2;
        chk(vga_de == 1'b0 && vga_hsync_n == 1'b1, "R1 R4 idle without a line",
            int'({vga_hsync_n, vga_de}), 2);
        send_field(0, 4, 1'b0);
        send_field(1, 1, 1'b0);
        send_field(2, 6, 1'b1);
        send_field(3, 3, 1'b0);
        repeat (4) @(posedge clk);
        #2;
        chk(out_runs == 2 * nsent, "R5 every line shown twice", out_runs, 2 * nsent);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule